// File: doc/BRIEF.md
# Two-Wire Converter Readout Slave

This block is the serial front end of a sampling converter that answers on a two-wire (I2C-style) bus. It oversamples the clock and data lines with the system clock, finds START, repeated START and STOP, and answers one of two 7-bit addresses picked by a strap input. When a read address matches, it acknowledges. It then delivers one 8-bit result per byte the master clocks out, most significant bit first. The master acknowledges each byte to ask for another, or sends a not-acknowledge to end the transfer.

A one-bit setup register selects how conversions are timed. The register is written through a write transfer. In internal mode, tracking begins on the falling clock edge that closes the acknowledge slot. The block then holds the bus clock low until a fresh result is stored. In external mode, the bus clock is never held. The byte returns the result of the previous conversion, and a new conversion starts in the background. A high-speed master code is recognised and is not acknowledged. The block stays in high-speed mode until the next STOP. The converter itself is a counter-based stub.

Top module: `tw_adc_slave`

## Requirements
- R1: The address byte is the 7-bit address followed by the read/write bit, where 1 means read. The address is 1100100 when `addr_sel_i` is 0 and 1100101 when it is 1. On a match, the slave pulls SDA low for the whole ninth clock of that byte.
- R2: After an address that does not match, the slave sends no acknowledge. It keeps SDA and SCL released for every further clock until the next START.
- R3: A byte whose top five bits are 00001 after a START is a master code. It gets no acknowledge and raises `hs_mode_o`. `hs_mode_o` stays high across repeated STARTs and falls after STOP.
- R4: After reset, both line drivers are off, `hs_mode_o` is 0, and the clock-mode bit is 0, which selects internal mode.
- R5: In internal mode, the slave pulls SCL low starting from the ninth falling edge of a read address byte, or of an acknowledged result byte. It spends 2 clock cycles tracking and then CONV_CYCLES cycles converting. It releases SCL only after the new result is on SDA.
- R6: Result bits go out most significant bit first. SDA changes only while SCL is low.
- R7: The master's bit in the ninth slot of a result byte is sampled on the rising SCL edge. A low bit (ACK) sends another byte with a new conversion. A high bit (NACK) leaves SDA released until STOP or a repeated START.
- R8: The n-th conversion since reset returns n modulo 256.
- R9: A matching write address is acknowledged, and so is every data byte after it. Bit 3 of each data byte (bit 7 is sent first) becomes the clock-mode bit, where 1 selects external mode.
- R10: In external mode, SCL is never pulled low. Each byte returns the latest stored result (0 before any conversion) and starts a new conversion.
- R11: A START or repeated START in any state returns the slave to waiting for an address byte. A byte cut short by a repeated START leaves the setup register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap choosing the address LSB |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low |
| hs_mode_o | output | 1 | High-speed mode entered by master code |

## Verification
Two events can land in the same cycle. The falling edge that ends the master's acknowledge also has to start the next byte's conversion, along with the clock hold in internal mode or the preload of the stored result in external mode. The bench provokes this with back-to-back acknowledged reads in both modes. It judges the outcome by the exact byte sequence, by whether the master saw its clock held, and by a per-clock monitor that flags any SDA change while SCL is high and any clock hold in external mode. A repeated START in the middle of a write byte checks that address wait wins over the unfinished data byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;
    localparam int TRACK_CYC = 2;
    localparam int TRK_W     = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TRACK,
        ST_CONV,
        ST_LOAD,
        ST_TX,
        ST_TX_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_IGNORE
    } tw_state_e;

    typedef struct packed {
        tw_state_e              state;
        logic [BIT_CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]      shreg;
        logic                   sda_oe;
        logic                   scl_oe;
        logic                   mack;
        logic                   clk_mode;
        logic                   hs;
        logic                   rw;
        logic [TRK_W-1:0]       trk;
        logic                   conv_go;
    } tw_regs_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;
    logic              last_d, last_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
        last_d = pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
            last_q <= 1'b1;
        end else begin
            pipe_q <= pipe_d;
            last_q <= last_d;
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~last_q;
    assign fall_o  = ~pipe_q[STAGES-1] & last_q;
endmodule

// File: rtl/tw_conv_stub.sv
module tw_conv_stub #(
    parameter int CONV_CYCLES = 10,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              done_o,
    output logic [DATA_W-1:0] value_o
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] value;
        logic              done;
    } stub_t;

    stub_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
            end
        end else if (s_q.cnt == LAST) begin
            s_d.busy  = 1'b0;
            s_d.done  = 1'b1;
            s_d.value = s_q.value + 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o  = s_q.done;
    assign value_o = s_q.value;

    // R8: a completed conversion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: each completion advances the result by one
    p_value_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> value_o == DATA_W'($past(value_o) + 1'b1));
endmodule

// File: rtl/tw_adc_slave.sv
module tw_adc_slave
    import tw_pkg::*;
#(
    parameter int CONV_CYCLES = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel_i,
    output logic scl_drive_low_o,
    output logic sda_drive_low_o,
    output logic hs_mode_o
);
    localparam logic [6:0]     ADDR_BASE = 7'b1100100;
    localparam logic [4:0]     MCODE_TOP = 5'b00001;
    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [TRK_W-1:0]     TRK_LAST = TRK_W'(TRACK_CYC - 1);

    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_det, stop_det;
    logic conv_done;
    logic [BYTE_W-1:0] conv_val;
    logic [6:0] own_addr;
    logic launch;

    tw_regs_t r_d, r_q;

    tw_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i),
        .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));

    tw_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i),
        .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

    tw_conv_stub #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(BYTE_W)) u_conv (
        .clk(clk), .rst_n(rst_n), .start_i(r_q.conv_go),
        .done_o(conv_done), .value_o(conv_val));

    assign start_det = sda_fall & scl_s;
    assign stop_det  = sda_rise & scl_s;
    assign own_addr  = {ADDR_BASE[6:1], addr_sel_i};

    always_comb begin
        r_d         = r_q;
        r_d.conv_go = 1'b0;
        launch      = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_IGNORE: ;
            ST_ADDR: begin
                if (scl_rise) begin
                    r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_s};
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                end else if (scl_fall && r_q.bitcnt == FULL) begin
                    if (r_q.shreg[7:3] == MCODE_TOP) begin
                        r_d.hs    = 1'b1;
                        r_d.state = ST_IGNORE;
                    end else if (r_q.shreg[7:1] == own_addr) begin
                        r_d.rw     = r_q.shreg[0];
                        r_d.sda_oe = 1'b1;
                        r_d.state  = ST_ADDR_ACK;
                    end else begin
                        r_d.state = ST_IGNORE;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    r_d.sda_oe = 1'b0;
                    if (r_q.rw) begin
                        launch = 1'b1;
                    end else begin
                        r_d.state  = ST_WR_DATA;
                        r_d.bitcnt = '0;
                    end
                end
            end
            ST_TRACK: begin
                if (r_q.trk == TRK_LAST) begin
                    r_d.conv_go = 1'b1;
                    r_d.state   = ST_CONV;
                end else begin
                    r_d.trk = r_q.trk + 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    r_d.shreg  = conv_val;
                    r_d.sda_oe = ~conv_val[BYTE_W-1];
                    r_d.state  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                r_d.scl_oe = 1'b0;
                r_d.state  = ST_TX;
            end
            ST_TX: begin
                if (scl_rise) begin
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                end else if (scl_fall) begin
                    if (r_q.bitcnt == FULL) begin
                        r_d.sda_oe = 1'b0;
                        r_d.state  = ST_TX_ACK;
                    end else begin
                        r_d.shreg  = {r_q.shreg[BYTE_W-2:0], 1'b0};
                        r_d.sda_oe = ~r_q.shreg[BYTE_W-2];
                    end
                end
            end
            ST_TX_ACK: begin
                if (scl_rise) begin
                    r_d.mack = ~sda_s;
                end else if (scl_fall) begin
                    if (r_q.mack) launch = 1'b1;
                    else          r_d.state = ST_IGNORE;
                end
            end
            ST_WR_DATA: begin
                if (scl_rise) begin
                    r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_s};
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                end else if (scl_fall && r_q.bitcnt == FULL) begin
                    r_d.clk_mode = r_q.shreg[3];
                    r_d.sda_oe   = 1'b1;
                    r_d.state    = ST_WR_ACK;
                end
            end
            ST_WR_ACK: begin
                if (scl_fall) begin
                    r_d.sda_oe = 1'b0;
                    r_d.bitcnt = '0;
                    r_d.state  = ST_WR_DATA;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (launch) begin
            r_d.bitcnt = '0;
            if (!r_q.clk_mode) begin
                r_d.scl_oe = 1'b1;
                r_d.sda_oe = 1'b0;
                r_d.trk    = '0;
                r_d.state  = ST_TRACK;
            end else begin
                r_d.shreg   = conv_val;
                r_d.sda_oe  = ~conv_val[BYTE_W-1];
                r_d.conv_go = 1'b1;
                r_d.state   = ST_TX;
            end
        end

        if (stop_det) begin
            r_d.state  = ST_IDLE;
            r_d.hs     = 1'b0;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
        end else if (start_det) begin
            r_d.state  = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low_o = r_q.scl_oe;
    assign sda_drive_low_o = r_q.sda_oe;
    assign hs_mode_o       = r_q.hs;

    // R3: STOP always leaves high-speed mode
    p_hs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !r_q.hs);
    // R10: external mode never holds the clock
    p_ext_nostretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.clk_mode |-> !r_q.scl_oe);
    // R6: data output frozen while the synchronised clock stays high
    p_sda_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(r_q.sda_oe));
    // R2: a slave that is not addressed drives nothing
    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IGNORE) |-> (!r_q.sda_oe && !r_q.scl_oe));
    // R5: clock released only with the result's MSB already on SDA
    p_release_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.scl_oe) |-> (r_q.sda_oe == ~r_q.shreg[BYTE_W-1]));
endmodule

// File: tb/tb_tw_adc_slave.sv
module tb_tw_adc_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic scl_oe, sda_oe, hs;
    logic scl_line, sda_line;

    int checks = 0, errors = 0;
    int stretch = 0;
    int conv_n = 0, last_res = 0;
    bit exp_ext = 1'b0;
    bit finished = 1'b0;
    int mon_stretch_err = 0, mon_sda_err = 0;
    logic prev_scl = 1'b1, prev_sda_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    tw_adc_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .scl_drive_low_o(scl_oe),
        .sda_drive_low_o(sda_oe), .hs_mode_o(hs));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-clock reference comparison of bus rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_ext && scl_oe) mon_stretch_err++;
            if (scl_line && prev_scl && (sda_oe != prev_sda_oe)) mon_sda_err++;
        end
        prev_scl    = scl_line;
        prev_sda_oe = sda_oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic rd);
        sda_m = b;
        wait_clk(HP);
        scl_m = 1'b1;
        stretch = 0;
        @(negedge clk);
        while (scl_line == 1'b0) begin
            stretch++;
            @(negedge clk);
        end
        wait_clk(HP/2);
        rd = sda_line;
        wait_clk(HP/2);
        scl_m = 1'b0;
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_clk(HP);
        scl_m = 1'b1; wait_clk(HP);
        sda_m = 1'b0; wait_clk(HP);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wait_clk(HP);
        scl_m = 1'b1; wait_clk(HP);
        sda_m = 1'b1; wait_clk(HP);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic rd;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], rd);
        clk_bit(1'b1, rd);
        acked = (rd == 1'b0);
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] v, output int st);
        logic rd;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, rd);
            v[i] = rd;
            if (i == 7) st = stretch;
        end
        clk_bit(ack ? 1'b0 : 1'b1, rd);
    endtask

    task automatic read_expect(input bit ack, input string tag);
        logic [7:0] v;
        int st, exp;
        if (!exp_ext) begin
            conv_n++; exp = conv_n % 256; last_res = exp;
        end else begin
            exp = last_res; conv_n++; last_res = conv_n % 256;
        end
        read_byte(ack, v, st);
        chk(v == exp[7:0], {tag, " R8 R6 byte value"}, v, exp);
        if (!exp_ext) chk(st > 0, {tag, " R5 clock held"}, st, 1);
        else          chk(st == 0, {tag, " R10 no hold"}, st, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        logic rd;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R4 reset state
        chk(!scl_oe && !sda_oe, "R4 drivers off", {scl_oe, sda_oe}, 0);
        chk(hs == 1'b0, "R4 hs low", hs, 0);

        // R1 R5 R7: internal read, three bytes
        do_start();
        send_byte({7'b1100100, 1'b1}, a);
        chk(a, "R1 read ack sel0", a, 1);
        read_expect(1'b1, "int1");
        read_expect(1'b1, "int2 R7 ack continues");
        read_expect(1'b0, "int3");
        clk_bit(1'b1, rd);
        chk(rd == 1'b1, "R7 SDA released after NACK", rd, 1);
        do_stop();

        // R2 wrong address
        do_start();
        send_byte({7'b1100101, 1'b1}, a);
        chk(!a, "R2 no ack on mismatch", a, 0);
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, rd);
            chk(rd == 1'b1 && stretch == 0, "R2 lines released", {rd, stretch != 0}, 2);
        end
        do_stop();

        // R3 master code, then repeated start read
        do_start();
        send_byte(8'b0000_1011, a);
        chk(!a, "R3 master code not acked", a, 0);
        chk(hs == 1'b1, "R3 hs entered", hs, 1);
        do_start();
        chk(hs == 1'b1, "R3 hs kept over Sr", hs, 1);
        send_byte({7'b1100100, 1'b1}, a);
        chk(a, "R11 addr after Sr acked", a, 1);
        read_expect(1'b0, "hs");
        do_stop();
        wait_clk(2);
        chk(hs == 1'b0, "R3 hs cleared by STOP", hs, 0);

        // R9 write setup selecting external mode, sel=1
        addr_sel = 1'b1;
        wait_clk(4);
        do_start();
        send_byte({7'b1100101, 1'b0}, a);
        chk(a, "R1 R9 write addr ack sel1", a, 1);
        send_byte(8'b0000_1000, a);
        chk(a, "R9 data byte acked", a, 1);
        do_stop();
        exp_ext = 1'b1;

        // R10 external reads
        do_start();
        send_byte({7'b1100101, 1'b1}, a);
        chk(a, "R10 read ack", a, 1);
        read_expect(1'b1, "ext1 R10");
        read_expect(1'b0, "ext2 R10");
        do_stop();

        // R11 repeated start cuts a write byte short
        do_start();
        send_byte({7'b1100101, 1'b0}, a);
        chk(a, "R11 write addr ack", a, 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, rd);
        do_start();
        send_byte({7'b1100101, 1'b1}, a);
        chk(a, "R11 addr accepted after Sr", a, 1);
        read_expect(1'b0, "ext3 R11 mode kept");
        do_start();
        send_byte({7'b1100101, 1'b0}, a);
        send_byte(8'b1111_0111, a);
        chk(a, "R9 back to internal acked", a, 1);
        do_stop();
        exp_ext = 1'b0;

        do_start();
        send_byte({7'b1100101, 1'b1}, a);
        chk(a, "R5 read ack", a, 1);
        read_expect(1'b0, "int4 R9 internal again");
        do_stop();

        chk(mon_stretch_err == 0, "R10 monitor no hold in ext", mon_stretch_err, 0);
        chk(mon_sda_err == 0, "R6 monitor SDA steady while SCL high", mon_sda_err, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule